// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a synchronous monostable timer. It watches three control inputs: an active-low trigger, an active-high trigger and an active-low clear. It also takes a duration value. When one of three gated trigger conditions is seen, it raises its output for a programmed number of clock cycles. Every input is registered once on the system clock. Edges are found by comparing that registered sample with the sample from the cycle before. A raw input change therefore reaches the output two clock edges later.

The timer is a two-state machine. In ST_IDLE the output is low. ST_IDLE moves to ST_ACTIVE on a START transition, which needs a valid trigger and a nonzero duration. ST_ACTIVE moves back to ST_IDLE on two transitions: EXPIRE, when the down-counter reaches its last cycle, and ABORT, when the clear input is sampled low. ST_ACTIVE also has a RELOAD self-transition. On RELOAD a fresh valid trigger restarts the count at the full duration, so a stream of triggers can stretch the pulse without limit. The duration is captured together with the trigger, so it can be changed freely between pulses.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: A rising edge on `trig_p_i` starts a pulse when `trig_n_i` is low and `clr_n_i` is high.
- R2: A falling edge on `trig_n_i` starts a pulse when `trig_p_i` is high and `clr_n_i` is high.
- R3: A rising edge on `clr_n_i` starts a pulse when `trig_n_i` is low and `trig_p_i` is high.
- R4: A valid trigger during an active pulse reloads the count. The pulse then ends exactly one full duration after the output of that latest trigger.
- R5: A low sample of `clr_n_i` ends an active pulse. If `clr_n_i` changes before clock edge k, `pulse_o` is low after edge k+1.
- R6: While `clr_n_i` is held low, edges on `trig_n_i` or `trig_p_i` start no pulse.
- R7: If an input changes before clock edge k, `pulse_o` is high after edges k+1 through k+D and low after edge k+D+1, where D is the duration. `pulse_n_o` is always the inverse of `pulse_o`.
- R8: A trigger whose duration is zero produces no pulse.
- R9: The duration is sampled in the same cycle as the trigger that uses it. Pulses of length 1 through the maximum value 2^DUR_W-1 are produced.
- R10: A synchronous reset on `rst` drives `pulse_o` low and clears the counter. Input levels that stay constant through the release of reset produce no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_n_i | input | 1 | Active-low trigger input |
| trig_p_i | input | 1 | Active-high trigger input |
| clr_n_i | input | 1 | Clear, active low; its rising edge is also a trigger |
| dur_i | input | DUR_W | Pulse length in clock cycles |
| pulse_o | output | 1 | Pulse output |
| pulse_n_o | output | 1 | Inverse of pulse_o |

## Verification
Some rules are checked by assertions on every cycle. A START or RELOAD loads exactly the sampled duration. The count falls by one per cycle while nothing interrupts it. A low clear sample always leads to ST_IDLE. A zero duration never leaves ST_IDLE. Reset clears both the state and the edge detectors. Other behaviour can only be shown by the bench's scenarios at the ports: the gating of the three trigger methods and the blocking of triggers while clear is held low, as well as the two-cycle latency, the exact pulse lengths and the extension of a pulse by retriggering.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } os_state_e;

    typedef struct packed {
        logic a_n;
        logic b;
        logic clr_n;
    } pin_sample_t;

endpackage

// File: rtl/oneshot_sampler.sv
module oneshot_sampler
    import oneshot_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_n_i,
    input  logic             b_i,
    input  logic             clr_n_i,
    input  logic [DUR_W-1:0] dur_i,
    output pin_sample_t      cur_o,
    output logic [DUR_W-1:0] dur_o,
    output logic             b_rise_o,
    output logic             a_fall_o,
    output logic             clr_rise_o
);

    pin_sample_t cur_q;
    pin_sample_t prev_q;
    pin_sample_t raw;
    logic [DUR_W-1:0] dur_q;

    assign raw = '{a_n: a_n_i, b: b_i, clr_n: clr_n_i};

    // During reset both stages follow the pins, so no edge appears on release.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= raw;
            prev_q <= raw;
            dur_q  <= '0;
        end else begin
            cur_q  <= raw;
            prev_q <= cur_q;
            dur_q  <= dur_i;
        end
    end

    always_comb begin
        b_rise_o   = cur_q.b & ~prev_q.b;
        a_fall_o   = ~cur_q.a_n & prev_q.a_n;
        clr_rise_o = cur_q.clr_n & ~prev_q.clr_n;
    end

    assign cur_o = cur_q;
    assign dur_o = dur_q;

    // R10: the cycle after a reset cycle shows no edge
    p_no_edge_after_reset_r10: assert property (@(posedge clk)
        rst |=> !(b_rise_o || a_fall_o || clr_rise_o));

endmodule

// File: rtl/oneshot_trig_decode.sv
module oneshot_trig_decode
    import oneshot_pkg::*;
(
    input  pin_sample_t cur_i,
    input  logic        b_rise_i,
    input  logic        a_fall_i,
    input  logic        clr_rise_i,
    output logic        fire_o,
    output logic        clear_o
);

    logic via_b;
    logic via_a;
    logic via_clr;

    always_comb begin
        via_b   = b_rise_i   & ~cur_i.a_n & cur_i.clr_n;
        via_a   = a_fall_i   &  cur_i.b   & cur_i.clr_n;
        via_clr = clr_rise_i & ~cur_i.a_n & cur_i.b;
        fire_o  = via_b | via_a | via_clr;
        clear_o = ~cur_i.clr_n;
    end

endmodule

// File: rtl/oneshot_timer_fsm.sv
module oneshot_timer_fsm
    import oneshot_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic             clear_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             active_o
);

    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    os_state_e        state_q, state_d;
    logic [DUR_W-1:0] cnt_q, cnt_d;
    logic             load_ok;

    assign load_ok = fire_i & (dur_i != '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_ok) begin          // START
                    state_d = ST_ACTIVE;
                    cnt_d   = dur_i;
                end
            end
            ST_ACTIVE: begin
                if (clear_i) begin          // ABORT
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (load_ok) begin // RELOAD
                    cnt_d   = dur_i;
                end else if (cnt_q == ONE) begin // EXPIRE
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - ONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active_o = (state_q == ST_ACTIVE);
    end

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && cnt_q == '0));

    p_clear_aborts_r5: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> state_q == ST_IDLE);

    p_reload_full_r4: assert property (@(posedge clk) disable iff (rst)
        (fire_i && !clear_i && dur_i != '0) |=>
            (state_q == ST_ACTIVE && cnt_q == $past(dur_i)));

    p_zero_no_start_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && (!fire_i || dur_i == '0)) |=> state_q == ST_IDLE);

    p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE && !fire_i && !clear_i && cnt_q > ONE) |=>
            (state_q == ST_ACTIVE && cnt_q == $past(cnt_q) - ONE));

    p_active_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE) |-> cnt_q != '0);

endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
    import oneshot_pkg::*;
#(
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_n_i,
    input  logic             trig_p_i,
    input  logic             clr_n_i,
    input  logic [DUR_W-1:0] dur_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    pin_sample_t      cur;
    logic [DUR_W-1:0] dur_s;
    logic             b_rise, a_fall, clr_rise;
    logic             fire, clear;
    logic             active;

    oneshot_sampler #(.DUR_W(DUR_W)) u_sampler (
        .clk        (clk),
        .rst        (rst),
        .a_n_i      (trig_n_i),
        .b_i        (trig_p_i),
        .clr_n_i    (clr_n_i),
        .dur_i      (dur_i),
        .cur_o      (cur),
        .dur_o      (dur_s),
        .b_rise_o   (b_rise),
        .a_fall_o   (a_fall),
        .clr_rise_o (clr_rise)
    );

    oneshot_trig_decode u_decode (
        .cur_i      (cur),
        .b_rise_i   (b_rise),
        .a_fall_i   (a_fall),
        .clr_rise_i (clr_rise),
        .fire_o     (fire),
        .clear_o    (clear)
    );

    oneshot_timer_fsm #(.DUR_W(DUR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .fire_i   (fire),
        .clear_i  (clear),
        .dur_i    (dur_s),
        .active_o (active)
    );

    assign pulse_o   = active;
    assign pulse_n_o = ~active;

    // R6: a clear sample blocks any pulse from starting on the next edge
    p_clear_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (clear && !pulse_o) |=> !pulse_o);

endmodule

// File: tb/oneshot_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module oneshot_pulse_gen_tb_top;

    localparam int DUR_W = 8;
    localparam int NVEC  = 43;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             trig_n = 1'b1;
    logic             trig_p = 1'b0;
    logic             clr_n = 1'b1;
    logic [DUR_W-1:0] dur = 8'd3;
    logic             pulse, pulse_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    oneshot_pulse_gen #(.DUR_W(DUR_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .trig_n_i  (trig_n),
        .trig_p_i  (trig_p),
        .clr_n_i   (clr_n),
        .dur_i     (dur),
        .pulse_o   (pulse),
        .pulse_n_o (pulse_n)
    );

    // {trig_n, trig_p, clr_n, dur, expected pulse at this negedge before driving}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b1,1'b0,1'b1,8'd3,1'b0},  // 0  idle
        {1'b1,1'b0,1'b1,8'd3,1'b0},  // 1
        {1'b0,1'b0,1'b1,8'd3,1'b0},  // 2  a falls, b low: no trigger
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 3  R1 b rise
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 4
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 5
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 6
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 7
        {1'b1,1'b1,1'b1,8'd3,1'b0},  // 8  ended after 3
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 9  R2 a fall
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 10
        {1'b0,1'b0,1'b1,8'd3,1'b1},  // 11
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 12 R4 retrigger via b rise
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 13
        {1'b0,1'b1,1'b0,8'd3,1'b1},  // 14 R5 clear low
        {1'b0,1'b1,1'b0,8'd3,1'b1},  // 15
        {1'b0,1'b1,1'b0,8'd3,1'b0},  // 16 aborted
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 17 R3 clear rise
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 18
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 19
        {1'b0,1'b1,1'b1,8'd3,1'b1},  // 20
        {1'b1,1'b0,1'b1,8'd3,1'b1},  // 21
        {1'b0,1'b0,1'b1,8'd3,1'b0},  // 22
        {1'b0,1'b1,1'b1,8'd0,1'b0},  // 23 R8 b rise, zero length
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 24
        {1'b0,1'b1,1'b1,8'd3,1'b0},  // 25
        {1'b1,1'b0,1'b1,8'd3,1'b0},  // 26
        {1'b1,1'b0,1'b0,8'd3,1'b0},  // 27 R6 hold clear low
        {1'b0,1'b0,1'b0,8'd3,1'b0},  // 28
        {1'b0,1'b1,1'b0,8'd3,1'b0},  // 29 b rise blocked
        {1'b0,1'b1,1'b0,8'd3,1'b0},  // 30
        {1'b0,1'b1,1'b0,8'd3,1'b0},  // 31
        {1'b1,1'b0,1'b1,8'd3,1'b0},  // 32 clear rise with a high: none
        {1'b1,1'b0,1'b1,8'd5,1'b0},  // 33
        {1'b0,1'b0,1'b1,8'd5,1'b0},  // 34
        {1'b0,1'b1,1'b1,8'd5,1'b0},  // 35 R9 length 5
        {1'b0,1'b1,1'b1,8'd5,1'b0},  // 36
        {1'b0,1'b1,1'b1,8'd5,1'b1},  // 37
        {1'b0,1'b1,1'b1,8'd5,1'b1},  // 38
        {1'b0,1'b1,1'b1,8'd5,1'b1},  // 39
        {1'b0,1'b1,1'b1,8'd5,1'b1},  // 40
        {1'b0,1'b1,1'b1,8'd5,1'b1},  // 41
        {1'b0,1'b1,1'b1,8'd5,1'b0}   // 42
    };

    function automatic string vec_tag(input int i);
        if (i < 3)  return "R7";
        if (i < 9)  return "R1";
        if (i < 12) return "R2";
        if (i < 14) return "R4";
        if (i < 17) return "R5";
        if (i < 22) return "R3";
        if (i < 27) return "R8";
        if (i < 33) return "R6";
        return "R9";
    endfunction

    task automatic check(input logic exp, input string tag);
        n_chk++;
        if (pulse !== exp || pulse_n !== ~exp) begin
            n_bad++;
            $display("FAIL %s: pulse=%b pulse_n=%b expected pulse=%b pulse_n=%b",
                     tag, pulse, pulse_n, exp, ~exp);
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic c, input logic [DUR_W-1:0] d);
        trig_n = a; trig_p = b; clr_n = c; dur = d;
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1'b0, "R10 reset state");

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check(VEC[i][0], vec_tag(i));
            drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:1]);
        end

        // R9: single-cycle pulse (inputs now a=0,b=1,clr=1)
        @(negedge clk); drive(1'b0, 1'b0, 1'b1, 8'd1);
        @(negedge clk); drive(1'b0, 1'b1, 1'b1, 8'd1);
        @(negedge clk); check(1'b0, "R9 length1 latency");
        @(negedge clk); check(1'b1, "R9 length1 high");
        @(negedge clk); check(1'b0, "R9 length1 end");

        // R9: maximum length 255
        drive(1'b0, 1'b0, 1'b1, 8'd255);
        @(negedge clk); drive(1'b0, 1'b1, 1'b1, 8'd255);
        @(negedge clk); drive(1'b0, 1'b1, 1'b1, 8'd7); // length change after trigger is not used
        hi = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (pulse === 1'b1) hi++;
        end
        n_chk++;
        if (hi != 255) begin
            n_bad++;
            $display("FAIL R9 max length: high cycles=%0d expected=255", hi);
        end

        // R10: reset in the middle of a pulse, then constant levels on release
        drive(1'b0, 1'b0, 1'b1, 8'd10);
        @(negedge clk); drive(1'b0, 1'b1, 1'b1, 8'd10);
        @(negedge clk);
        @(negedge clk); check(1'b1, "R10 pulse before reset");
        rst = 1'b1;
        @(negedge clk); check(1'b0, "R10 reset mid-pulse");
        drive(1'b1, 1'b1, 1'b0, 8'd10);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 8'd10);  // would be a trigger if an edge were seen
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(1'b0, "R10 no false edge after reset");
        end

        // R4: retrigger chain keeps pulse high past one duration
        drive(1'b0, 1'b0, 1'b1, 8'd2);
        @(negedge clk); drive(1'b0, 1'b1, 1'b1, 8'd2);   // trigger t0
        @(negedge clk); drive(1'b0, 1'b0, 1'b1, 8'd2);
        @(negedge clk); check(1'b1, "R4 chain start"); drive(1'b0, 1'b1, 1'b1, 8'd2); // trigger t1
        @(negedge clk); check(1'b1, "R4 chain");
        @(negedge clk); check(1'b1, "R4 chain reload");
        @(negedge clk); check(1'b1, "R4 chain last");
        @(negedge clk); check(1'b0, "R4 chain end");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule